// File: doc/BRIEF.md
# Received-MPDU Completion Record Builder

This block emits a 128-bit completion record, laid out as four 32-bit words, each time the receive path reports the end of an MPDU. The record gathers the frame's classification (filter category and software frame group), the error flags raised by upstream stages, the decrypt outcome and the two destination ring selections. It also carries three values that the block keeps itself: an identifier for the current PPDU, a global timestamp taken when the receive-frame signal first rises in that PPDU, and a management sequence number.

The PPDU identifier advances on every PPDU start strobe. The timestamp is taken once per PPDU and repeated in every record of that PPDU. The management sequence counter stamps only those management frames that are addressed to this device, arrived with a good FCS and fall in a category selected for numbering. A downstream DMA or descriptor writer takes the record on the cycle its valid pulse is high.

Top module: `mpdu_end_rec_gen`

## Requirements
- R1: Word 0 (record bits [31:0]) carries the filter category in bits [1:0] (0 normal pass, 1 monitor client, 2 monitor other, 3 pass with monitor override), the frame group in bits [8:2], zeros in bits [15:9] and the PPDU identifier in bits [31:16].
- R2: The PPDU identifier is 0 after reset, rises by one on each cycle with `ppdu_start_i` high, and wraps from 0xFFFF to 0.
- R3: Word 1 (record bits [63:32]) places `stat_flags_i[i]` at word bit 11+i, where i = 0 unsupported key type on a short frame, 1 decrypt skipped while crypto serves transmit, 2 FIFO overflow, 3 MPDU length error, 4 TKIP MIC error, 5 decrypt error, 6 unencrypted-frame error, 7 PN valid, 8 FCS error, 9 MSDU length error.
- R4: Word 1 carries the ring 0 selection in bits [23:21], the ring 1 selection in bits [26:24] and the bitmap-not-updated flag in bit 30; bits [10:0] and 31 are zero.
- R5: Word 1 bits [29:27] carry the decrypt status (0 ok, 1 unprotected, 2 MIC/ICV error, 3 invalid key, 4 invalid peer entry, 5 other); an input of 6 or 7 is recorded as 5.
- R6: A frame qualifies for a sequence number when `is_mgmt_i`, `for_self_i` and `seq_class_i` are all high and `stat_flags_i[8]` (FCS error) is low. A qualifying frame receives the current count, which is 0 after reset, and the count then rises by one, wrapping from 0xFFFF to 0; a non-qualifying frame leaves the count unchanged.
- R7: Word 2 (record bits [95:64]) carries the sequence-valid flag in bit 15 and the sequence number in bits [31:16]; bits [14:0] are zero, and the number field is zero when the flag is clear.
- R8: Word 3 (record bits [127:96]) holds `gts_i` as sampled on the first rising edge of `rx_frame_i` after a PPDU start (or after reset); further rising edges before the next PPDU start are ignored. It is 0 after reset.
- R9: `rec_valid_o` is high exactly on the cycle after each cycle with `mpdu_end_i` high, and `rec_o` then holds the fields sampled at that strobe; `rec_o` is unchanged on every cycle that follows a cycle without the strobe, and both outputs are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ppdu_start_i | input | 1 | Start of a new PPDU |
| rx_frame_i | input | 1 | Receive-frame level signal |
| gts_i | input | 32 | Global timestamp bus |
| mpdu_end_i | input | 1 | End-of-MPDU strobe; fields below are sampled with it |
| filt_cat_i | input | 2 | Filter category |
| frame_grp_i | input | 7 | Software frame group |
| stat_flags_i | input | 10 | Error and status flags (order in R3) |
| ring0_sel_i | input | 3 | Destination ring for the first DMA path |
| ring1_sel_i | input | 3 | Destination ring for the second DMA path |
| dec_status_i | input | 3 | Decrypt status code |
| bitmap_miss_i | input | 1 | Receive bitmap could not be updated |
| is_mgmt_i | input | 1 | Frame is a management frame |
| for_self_i | input | 1 | Frame is addressed to this device |
| seq_class_i | input | 1 | Frame belongs to a category selected for numbering |
| rec_valid_o | output | 1 | One-cycle record valid pulse |
| rec_o | output | 128 | Completion record, word 0 in the low bits |

## Verification
The assertions assume `ppdu_start_i` and a rising edge of `rx_frame_i` never fall on the same cycle, and that `mpdu_end_i` does not coincide with a PPDU start or a timestamp capture, so each record sees settled identifier and timestamp values. The bench keeps to this by spacing the PPDU start, the two receive-frame edges and the MPDU strobes on separate cycles. It sweeps every filter category, every decrypt code including the two illegal ones, and all sixteen combinations of the four sequence-qualifying conditions, then drives both 16-bit counters through their wrap.

// File: rtl/mpdu_rec_pkg.sv
// Shared widths, record layout constants and helpers for the MPDU
// completion record builder. Bit positions here are the layout that
// downstream consumers decode, so they are fixed.
package mpdu_rec_pkg;

    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 4;
    localparam int REC_W     = WORD_W * NUM_WORDS;

    localparam int CAT_W   = 2;
    localparam int GRP_W   = 7;
    localparam int ID_W    = 16;
    localparam int NFLAG   = 10;
    localparam int RING_W  = 3;
    localparam int DEC_W   = 3;
    localparam int SEQ_W   = 16;
    localparam int TS_W    = 32;

    // Derived layout widths
    localparam int W0_PAD_W  = WORD_W - ID_W - GRP_W - CAT_W;   // 7
    localparam int FLAG_LSB  = 11;
    localparam int W1_TOP_W  = WORD_W - FLAG_LSB - NFLAG - 2*RING_W - DEC_W - 1; // 1
    localparam int W2_PAD_W  = WORD_W - SEQ_W - 1;              // 15

    // Index of the FCS error flag inside the flag vector
    localparam int FCS_IDX = 8;

    // Largest legal decrypt status code ("other")
    localparam logic [DEC_W-1:0] DEC_LAST = 3'd5;

    // Map an out-of-range decrypt status onto the "other" code.
    function automatic logic [DEC_W-1:0] legal_dec(input logic [DEC_W-1:0] code);
        return (code > DEC_LAST) ? DEC_LAST : code;
    endfunction

endpackage

// File: rtl/ppdu_tracker.sv
// PPDU tracker: keeps the per-PPDU identifier and the receive-frame
// timestamp. The identifier advances on each PPDU start and wraps. The
// timestamp is taken on the first rising edge of rx_frame after a PPDU
// start (or after reset) and held until the next start re-arms it.
// Assumes a PPDU start and an rx_frame rising edge never share a cycle.
module ppdu_tracker #(
    parameter int ID_W = 16,
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ppdu_start_i,
    input  logic            rx_frame_i,
    input  logic [TS_W-1:0] gts_i,
    output logic [ID_W-1:0] ppdu_id_o,
    output logic [TS_W-1:0] frame_ts_o
);

    logic [ID_W-1:0] id_q;
    logic [TS_W-1:0] ts_q;
    logic            armed_q;
    logic            rx_prev_q;
    logic            rx_rise;

    // Rising edge of the receive-frame level
    assign rx_rise = rx_frame_i & ~rx_prev_q;

    // Identifier counter, edge-detect history and timestamp capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q      <= '0;
            ts_q      <= '0;
            armed_q   <= 1'b1;
            rx_prev_q <= 1'b0;
        end else begin
            rx_prev_q <= rx_frame_i;
            if (ppdu_start_i) begin
                id_q    <= id_q + 1'b1;
                armed_q <= 1'b1;
            end else if (rx_rise && armed_q) begin
                ts_q    <= gts_i;
                armed_q <= 1'b0;
            end
        end
    end

    assign ppdu_id_o  = id_q;
    assign frame_ts_o = ts_q;

    // R2
    id_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ppdu_start_i |=> (id_q == $past(id_q) + 1'b1));

    // R2
    id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ppdu_start_i |=> $stable(id_q));

    // R8
    ts_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rise && armed_q && !ppdu_start_i) |=> (ts_q == $past(gts_i)));

    // R8
    ts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && !ppdu_start_i) |=> $stable(ts_q));

endmodule

// File: rtl/mgmt_seq_stamper.sv
// Management sequence stamper: decides whether the ending MPDU
// qualifies for a management sequence number and keeps the counter
// that supplies it. The current count is handed out, then advanced.
// Assumes the FCS flag is final when the MPDU-end strobe is seen.
module mgmt_seq_stamper #(
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mpdu_end_i,
    input  logic             is_mgmt_i,
    input  logic             for_self_i,
    input  logic             seq_class_i,
    input  logic             fcs_err_i,
    output logic             stamp_o,
    output logic [SEQ_W-1:0] seq_o
);

    logic [SEQ_W-1:0] cnt_q;
    logic             qualify;

    // Qualification: management, addressed here, selected class, good FCS
    assign qualify = is_mgmt_i & for_self_i & seq_class_i & ~fcs_err_i;
    assign stamp_o = qualify;
    assign seq_o   = cnt_q;

    // Advance the counter after each number handed out
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (mpdu_end_i && qualify) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mpdu_end_i && is_mgmt_i && for_self_i && seq_class_i && !fcs_err_i)
        |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R6
    seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mpdu_end_i && is_mgmt_i && for_self_i && seq_class_i && !fcs_err_i)
        |=> $stable(cnt_q));

endmodule

// File: rtl/rec_packer.sv
// Record packer: assembles the four record words from the sampled MPDU
// fields and the tracked PPDU state, and registers them on the MPDU-end
// strobe. The valid pulse follows the strobe by one cycle; the record
// holds its value until the next strobe. Reserved bits are zero.
module rec_packer
    import mpdu_rec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mpdu_end_i,
    input  logic [CAT_W-1:0]  filt_cat_i,
    input  logic [GRP_W-1:0]  frame_grp_i,
    input  logic [NFLAG-1:0]  stat_flags_i,
    input  logic [RING_W-1:0] ring0_sel_i,
    input  logic [RING_W-1:0] ring1_sel_i,
    input  logic [DEC_W-1:0]  dec_status_i,
    input  logic              bitmap_miss_i,
    input  logic [ID_W-1:0]   ppdu_id_i,
    input  logic [TS_W-1:0]   frame_ts_i,
    input  logic              stamp_i,
    input  logic [SEQ_W-1:0]  seq_i,
    output logic              rec_valid_o,
    output logic [REC_W-1:0]  rec_o
);

    logic [NUM_WORDS-1:0][WORD_W-1:0] word_d;
    logic [NUM_WORDS-1:0][WORD_W-1:0] word_q;
    logic                             valid_q;
    logic [SEQ_W-1:0]                 seq_field;

    // Number field is forced to zero when the frame is not stamped
    assign seq_field = stamp_i ? seq_i : '0;

    // Build the next record words from the current inputs
    always_comb begin
        word_d[0] = {ppdu_id_i, {W0_PAD_W{1'b0}}, frame_grp_i, filt_cat_i};
        word_d[1] = {{W1_TOP_W{1'b0}}, bitmap_miss_i, legal_dec(dec_status_i),
                     ring1_sel_i, ring0_sel_i, stat_flags_i, {FLAG_LSB{1'b0}}};
        word_d[2] = {seq_field, stamp_i, {W2_PAD_W{1'b0}}};
        word_d[3] = frame_ts_i;
    end

    // One load-enabled register per record word
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q[w] <= '0;
            end else if (mpdu_end_i) begin
                word_q[w] <= word_d[w];
            end
        end
    end

    // Valid pulse one cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= mpdu_end_i;
        end
    end

    assign rec_o       = word_q;
    assign rec_valid_o = valid_q;

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mpdu_end_i |=> rec_valid_o);

    // R9
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mpdu_end_i |=> (!rec_valid_o && $stable(rec_o)));

    // R4
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid_o |-> (rec_o[15:9] == '0 && rec_o[42:32] == '0 &&
                         rec_o[63] == 1'b0 && rec_o[78:64] == '0));

    // R5
    dec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid_o |-> (rec_o[61:59] <= DEC_LAST));

    // R7
    seq_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid_o && !rec_o[79]) |-> (rec_o[95:80] == '0));

endmodule

// File: rtl/mpdu_end_rec_gen.sv
// MPDU completion record builder (top). Ties the PPDU tracker, the
// management sequence stamper and the record packer together. Assumes
// the MPDU-end strobe never shares a cycle with a PPDU start or with the
// timestamp capture edge, so each record sees settled PPDU state.
module mpdu_end_rec_gen
    import mpdu_rec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ppdu_start_i,
    input  logic              rx_frame_i,
    input  logic [TS_W-1:0]   gts_i,
    input  logic              mpdu_end_i,
    input  logic [CAT_W-1:0]  filt_cat_i,
    input  logic [GRP_W-1:0]  frame_grp_i,
    input  logic [NFLAG-1:0]  stat_flags_i,
    input  logic [RING_W-1:0] ring0_sel_i,
    input  logic [RING_W-1:0] ring1_sel_i,
    input  logic [DEC_W-1:0]  dec_status_i,
    input  logic              bitmap_miss_i,
    input  logic              is_mgmt_i,
    input  logic              for_self_i,
    input  logic              seq_class_i,
    output logic              rec_valid_o,
    output logic [REC_W-1:0]  rec_o
);

    logic [ID_W-1:0]  ppdu_id;
    logic [TS_W-1:0]  frame_ts;
    logic             stamp;
    logic [SEQ_W-1:0] seq_num;

    ppdu_tracker #(
        .ID_W (ID_W),
        .TS_W (TS_W)
    ) u_ppdu (
        .clk          (clk),
        .rst_n        (rst_n),
        .ppdu_start_i (ppdu_start_i),
        .rx_frame_i   (rx_frame_i),
        .gts_i        (gts_i),
        .ppdu_id_o    (ppdu_id),
        .frame_ts_o   (frame_ts)
    );

    mgmt_seq_stamper #(
        .SEQ_W (SEQ_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .mpdu_end_i  (mpdu_end_i),
        .is_mgmt_i   (is_mgmt_i),
        .for_self_i  (for_self_i),
        .seq_class_i (seq_class_i),
        .fcs_err_i   (stat_flags_i[FCS_IDX]),
        .stamp_o     (stamp),
        .seq_o       (seq_num)
    );

    rec_packer u_pack (
        .clk           (clk),
        .rst_n         (rst_n),
        .mpdu_end_i    (mpdu_end_i),
        .filt_cat_i    (filt_cat_i),
        .frame_grp_i   (frame_grp_i),
        .stat_flags_i  (stat_flags_i),
        .ring0_sel_i   (ring0_sel_i),
        .ring1_sel_i   (ring1_sel_i),
        .dec_status_i  (dec_status_i),
        .bitmap_miss_i (bitmap_miss_i),
        .ppdu_id_i     (ppdu_id),
        .frame_ts_i    (frame_ts),
        .stamp_i       (stamp),
        .seq_i         (seq_num),
        .rec_valid_o   (rec_valid_o),
        .rec_o         (rec_o)
    );

endmodule

// File: tb/mpdu_end_rec_gen_test.sv
module mpdu_end_rec_gen_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ppdu_start_i = 1'b0;
    logic         rx_frame_i = 1'b0;
    logic [31:0]  gts_i = '0;
    logic         mpdu_end_i = 1'b0;
    logic [1:0]   filt_cat_i = '0;
    logic [6:0]   frame_grp_i = '0;
    logic [9:0]   stat_flags_i = '0;
    logic [2:0]   ring0_sel_i = '0;
    logic [2:0]   ring1_sel_i = '0;
    logic [2:0]   dec_status_i = '0;
    logic         bitmap_miss_i = 1'b0;
    logic         is_mgmt_i = 1'b0;
    logic         for_self_i = 1'b0;
    logic         seq_class_i = 1'b0;
    logic         rec_valid_o;
    logic [127:0] rec_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // Bench model of the block's own state
    logic [15:0] m_id = '0;
    logic [15:0] m_seq = '0;
    logic [31:0] m_ts = '0;

    always #2.5 clk = ~clk;

    mpdu_end_rec_gen uut (
        .clk(clk), .rst_n(rst_n), .ppdu_start_i(ppdu_start_i),
        .rx_frame_i(rx_frame_i), .gts_i(gts_i), .mpdu_end_i(mpdu_end_i),
        .filt_cat_i(filt_cat_i), .frame_grp_i(frame_grp_i),
        .stat_flags_i(stat_flags_i), .ring0_sel_i(ring0_sel_i),
        .ring1_sel_i(ring1_sel_i), .dec_status_i(dec_status_i),
        .bitmap_miss_i(bitmap_miss_i), .is_mgmt_i(is_mgmt_i),
        .for_self_i(for_self_i), .seq_class_i(seq_class_i),
        .rec_valid_o(rec_valid_o), .rec_o(rec_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // New PPDU: start pulse, capture a on the first rx_frame rise,
    // then a second rise with b on the bus which must be ignored (R8).
    task automatic new_ppdu(input logic [31:0] a, input logic [31:0] b);
        ppdu_start_i = 1'b1;
        rx_frame_i = 1'b0;
        gts_i = a;
        @(negedge clk);
        ppdu_start_i = 1'b0;
        m_id = m_id + 16'd1;
        rx_frame_i = 1'b1;
        @(negedge clk);
        m_ts = a;
        gts_i = b;
        rx_frame_i = 1'b0;
        @(negedge clk);
        rx_frame_i = 1'b1;
        @(negedge clk);
        rx_frame_i = 1'b0;
        @(negedge clk);
    endtask

    // One MPDU end, with every record word checked against the model
    task automatic send_mpdu(input logic [1:0] cat, input logic [6:0] grp,
                             input logic [9:0] flg, input logic [2:0] r0,
                             input logic [2:0] r1, input logic [2:0] dec,
                             input logic bmp, input logic [2:0] q);
        logic        qual;
        logic [2:0]  dexp;
        logic [31:0] e0, e1, e2, e3;
        filt_cat_i = cat; frame_grp_i = grp; stat_flags_i = flg;
        ring0_sel_i = r0; ring1_sel_i = r1; dec_status_i = dec;
        bitmap_miss_i = bmp;
        is_mgmt_i = q[0]; for_self_i = q[1]; seq_class_i = q[2];
        mpdu_end_i = 1'b1;
        qual = q[0] & q[1] & q[2] & ~flg[8];
        dexp = (dec > 3'd5) ? 3'd5 : dec;
        e0 = {m_id, 7'd0, grp, cat};
        e1 = {1'b0, bmp, dexp, r1, r0, flg, 11'd0};
        e2 = qual ? {m_seq, 1'b1, 15'd0} : 32'd0;
        e3 = m_ts;
        if (qual) m_seq = m_seq + 16'd1;
        @(negedge clk);
        mpdu_end_i = 1'b0;
        chk("R9 valid after strobe", {31'd0, rec_valid_o}, 32'd1);
        chk("R1/R2 word0", rec_o[31:0], e0);
        chk("R3/R4/R5 word1", rec_o[63:32], e1);
        chk("R6/R7 word2", rec_o[95:64], e2);
        chk("R8 word3", rec_o[127:96], e3);
        @(negedge clk);
        chk("R9 valid one cycle", {31'd0, rec_valid_o}, 32'd0);
        chk("R9 record held", rec_o[63:32], e1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // Reset state (R9, R2, R8)
        chk("R9 reset valid", {31'd0, rec_valid_o}, 32'd0);
        chk("R9 reset word0", rec_o[31:0], 32'd0);
        chk("R9 reset word3", rec_o[127:96], 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Before any PPDU: identifier 0, timestamp 0, sequence 0 (R2, R8, R6)
        send_mpdu(2'd0, 7'd3, 10'h000, 3'd2, 3'd2, 3'd0, 1'b0, 3'b111);

        // Sweep categories, decrypt codes and qualification combinations
        for (int n = 0; n < 512; n++) begin
            logic [9:0] flg;
            int qv;
            if (n % 16 == 0)
                new_ppdu(32'(n) * 32'h9E3779B1 + 32'd7, 32'hDEAD0000 | 32'(n));
            qv = (n / 32) % 16;
            flg = 10'((n * 37) % 1024);
            flg[8] = qv[3];
            send_mpdu(2'(n % 4), 7'(n % 40), flg, 3'(n % 7), 3'((n / 7) % 8),
                      3'((n / 4) % 8), n[0], 3'(qv));
        end

        // Sequence wrap (R6, R7): advance the counter to 0xFFFF
        begin
            int k;
            k = 16'hFFFF - int'(m_seq);
            filt_cat_i = 2'd0; stat_flags_i = 10'h000;
            is_mgmt_i = 1'b1; for_self_i = 1'b1; seq_class_i = 1'b1;
            mpdu_end_i = (k > 0);
            repeat (k) @(negedge clk);
            mpdu_end_i = 1'b0;
            m_seq = m_seq + 16'(k);
            @(negedge clk);
        end
        send_mpdu(2'd1, 7'd4, 10'h080, 3'd1, 3'd2, 3'd1, 1'b0, 3'b111);
        send_mpdu(2'd1, 7'd5, 10'h080, 3'd1, 3'd2, 3'd1, 1'b0, 3'b111);
        chk("R6 seq wrapped to zero", {16'd0, m_seq}, 32'd1);

        // Identifier wrap (R2): step the identifier to 0xFFFF
        begin
            int k;
            k = 16'hFFFF - int'(m_id);
            ppdu_start_i = (k > 0);
            repeat (k) @(negedge clk);
            ppdu_start_i = 1'b0;
            m_id = m_id + 16'(k);
            @(negedge clk);
        end
        send_mpdu(2'd3, 7'd37, 10'h3FF, 3'd6, 3'd7, 3'd7, 1'b1, 3'b000);
        new_ppdu(32'h12345678, 32'h87654321);
        send_mpdu(2'd2, 7'd39, 10'h155, 3'd3, 3'd0, 3'd6, 1'b1, 3'b011);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule